// File: doc/BRIEF.md
# Dithered Nibble Combine Blitter

This block copies a rectangle of 4-bit pixels from a source bitmap into a destination bitmap. It does not store source pixels directly. Each destination pixel is replaced by a nibble taken from a 256-word combine table. The table is indexed by the source pixel and the old destination pixel together. Each table word holds four candidate results. The destination pixel's X and Y parity selects one of them, so a single table describes an ordered 2x2 texture. This gives more apparent shades than the sixteen pixel codes alone.

Pixels are packed four to a 16-bit word. The block reaches memory through one shared word port with a request/ready handshake. All table reads, source reads and destination read-modify-writes are serialized on that port.

Lines are processed from the bottom of the rectangle upward. The first line can be resumed part-way through. A stop request is honoured only between lines, and the remaining line count is reported so that software can restart the operation later.

Top module: `nib_blit`

## Requirements
- R1: Pixel x occupies nibble x mod 4 of its word, and nibble 0 is bits 15:12. Word address = bitmap base + y * pitch + x / 4, with pitch counted in words.
- R2: The table word for a pixel is read at address {tbl_page, src_nibble, dst_nibble}. The table page supplies the upper address bits and the 8-bit index the lower 8; no adder is involved.
- R3: The new destination nibble is field 2*(dst_y mod 2) + (dst_x mod 2) of the table word, where field 0 is bits 15:12 and field 3 is bits 3:0.
- R4: Source and destination may start at different nibble offsets. Each side fetches its next word only after its nibble 3 has been used.
- R5: A destination word is written back once per line, either when its nibble 3 is replaced or when the line ends. Nibbles and words outside the rectangle keep their old values.
- R6: Lines run bottom-up. The first write of an operation goes to the destination word of line y + height - 1.
- R7: A nonzero resume_left makes the first (bottom) line start at X offset width - resume_left and cover only resume_left pixels. Later lines cover the full width.
- R8: stop_req is sampled only after a line completes. When it is set and lines remain, the block ends with stopped = 1 and lines_left = the number of unprocessed lines, and it leaves lines above untouched.
- R9: done pulses for one cycle at the end of an operation and busy is low with it. A height of 0 ends at once with no memory access and lines_left = 0.
- R10: mem_req, mem_addr, mem_we and mem_wdata stay stable from the cycle a request is raised until mem_ready is seen. No request is raised while the block is idle.
- R11: start is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| tbl_page | input | AW-8 | Upper address bits of the combine table |
| src_base | input | AW | Word address of source line 0 |
| src_pitch | input | AW | Source words per line |
| src_x | input | CW | Source rectangle left X |
| src_y | input | CW | Source rectangle top Y |
| dst_base | input | AW | Word address of destination line 0 |
| dst_pitch | input | AW | Destination words per line |
| dst_x | input | CW | Destination rectangle left X |
| dst_y | input | CW | Destination rectangle top Y |
| width | input | CW | Pixels per line |
| height | input | CW | Lines to process |
| resume_left | input | CW | Pixels still to do on the first line, 0 = fresh |
| stop_req | input | 1 | Stop at the next line boundary |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| stopped | output | 1 | Last operation ended by stop_req |
| lines_left | output | CW | Lines not yet processed |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 16 | Read data |

## Verification
The memory model answers each request one cycle after it sees it. The block then needs one further cycle to choose its next access, so a pixel that needs no new words costs three cycles. The memory contents, lines_left and stopped are all final in the cycle done is high. The bench therefore waits for done on falling clock edges and checks only there, comparing the whole memory image against a bench-computed image. The first write address and the write count are taken from the model's log of accepted writes. They are compared with the values that the bottom-up order and the once-per-word writeback rule predict.

// File: rtl/nib_blit_pkg.sv
package nib_blit_pkg;
  localparam int WORD_W = 16;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_LINE, ST_PICK, ST_WAIT, ST_LEND} st_t;
  typedef enum logic [1:0] {AC_SRC, AC_DST, AC_TBL, AC_WR} acc_t;

  // field k of a word, field 0 in the top bits
  function automatic logic [NIB_W-1:0] nib_at(input logic [WORD_W-1:0] w, input logic [1:0] k);
    return w[(3 - int'(k)) * NIB_W +: NIB_W];
  endfunction
endpackage

// File: rtl/nb_row_gen.sv
module nb_row_gen #(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pitch,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] height,
  output logic [AW-1:0] row
);
  logic [AW-1:0] pitch_q;
  logic [CW-1:0] ybot;

  assign ybot = y + height - CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      row     <= '0;
      pitch_q <= '0;
    end else if (load) begin
      row     <= base + AW'(AW'(ybot) * pitch);
      pitch_q <= pitch;
    end else if (step) begin
      row <= row - pitch_q;
    end
  end
endmodule

// File: rtl/nb_combine.sv
module nb_combine
  import nib_blit_pkg::*;
(
  input  logic [WORD_W-1:0] sword,
  input  logic [1:0]        sidx,
  input  logic [WORD_W-1:0] dword,
  input  logic [1:0]        didx,
  input  logic [WORD_W-1:0] tword,
  input  logic [1:0]        sel,
  output logic [7:0]        index,
  output logic [WORD_W-1:0] merged
);
  always_comb begin
    index  = {nib_at(sword, sidx), nib_at(dword, didx)};
    merged = dword;
    merged[(3 - int'(didx)) * NIB_W +: NIB_W] = nib_at(tword, sel);
  end
endmodule

// File: rtl/nib_blit.sv
module nib_blit
  import nib_blit_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-9:0] tbl_page,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] src_pitch,
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  input  logic [AW-1:0] dst_base,
  input  logic [AW-1:0] dst_pitch,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  input  logic [CW-1:0] resume_left,
  input  logic          stop_req,
  output logic          busy,
  output logic          done,
  output logic          stopped,
  output logic [CW-1:0] lines_left,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [15:0]   mem_rdata
);
  st_t           st;
  acc_t          acc;
  logic [AW-9:0] tbl_q;
  logic [CW-1:0] sx_q, dx_q, w_q, res_q, cnt;
  logic          dy0_q, first, ypar;
  logic [15:0]   sreg, dreg;
  logic [AW-1:0] saddr, daddr, wr_addr, srow, drow;
  logic [1:0]    snib, dnib;
  logic          need_s, need_d, pend_wr;
  logic          load, step, part;
  logic [CW-1:0] xoff, sxs, dxs;
  logic [7:0]    tidx;
  logic [15:0]   merged;

  assign load = start && (st == ST_IDLE);
  assign step = (st == ST_LEND) && (lines_left > CW'(1)) && !stop_req;
  assign part = first && (res_q != '0);
  assign xoff = part ? (w_q - res_q) : '0;
  assign sxs  = sx_q + xoff;
  assign dxs  = dx_q + xoff;

  nb_row_gen #(.AW(AW), .CW(CW)) u_srow (
    .clk(clk), .rst(rst), .load(load), .step(step), .base(src_base),
    .pitch(src_pitch), .y(src_y), .height(height), .row(srow));

  nb_row_gen #(.AW(AW), .CW(CW)) u_drow (
    .clk(clk), .rst(rst), .load(load), .step(step), .base(dst_base),
    .pitch(dst_pitch), .y(dst_y), .height(height), .row(drow));

  nb_combine u_cmb (
    .sword(sreg), .sidx(snib), .dword(dreg), .didx(dnib),
    .tword(mem_rdata), .sel({ypar, dnib[0]}), .index(tidx), .merged(merged));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; acc <= AC_SRC;
      busy <= 1'b0; done <= 1'b0; stopped <= 1'b0; lines_left <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      tbl_q <= '0; sx_q <= '0; dx_q <= '0; w_q <= '0; res_q <= '0; dy0_q <= 1'b0;
      cnt <= '0; first <= 1'b0; ypar <= 1'b0; sreg <= '0; dreg <= '0;
      saddr <= '0; daddr <= '0; wr_addr <= '0; snib <= '0; dnib <= '0;
      need_s <= 1'b0; need_d <= 1'b0; pend_wr <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          tbl_q <= tbl_page; sx_q <= src_x; dx_q <= dst_x;
          w_q <= width; res_q <= resume_left; dy0_q <= dst_y[0];
          stopped <= 1'b0; first <= 1'b1; lines_left <= height;
          if (height == '0) done <= 1'b1;
          else begin busy <= 1'b1; st <= ST_LINE; end
        end
        ST_LINE: begin
          cnt   <= part ? res_q : w_q;
          saddr <= srow + AW'(sxs >> 2);
          daddr <= drow + AW'(dxs >> 2);
          snib  <= sxs[1:0];
          dnib  <= dxs[1:0];
          ypar  <= dy0_q ^ ~lines_left[0];  // parity of dst_y + lines_left - 1
          need_s <= 1'b1; need_d <= 1'b1; pend_wr <= 1'b0; first <= 1'b0;
          st <= ST_PICK;
        end
        ST_PICK: begin
          st <= ST_WAIT;
          mem_req <= 1'b1;
          mem_we  <= 1'b0;
          if (pend_wr) begin
            acc <= AC_WR; mem_we <= 1'b1; mem_addr <= wr_addr; mem_wdata <= dreg;
          end else if (cnt == '0) begin
            mem_req <= 1'b0; st <= ST_LEND;
          end else if (need_s) begin
            acc <= AC_SRC; mem_addr <= saddr;
          end else if (need_d) begin
            acc <= AC_DST; mem_addr <= daddr;
          end else begin
            acc <= AC_TBL; mem_addr <= {tbl_q, tidx};
          end
        end
        ST_WAIT: if (mem_ready) begin
          mem_req <= 1'b0; mem_we <= 1'b0; st <= ST_PICK;
          case (acc)
            AC_SRC: begin sreg <= mem_rdata; need_s <= 1'b0; end
            AC_DST: begin dreg <= mem_rdata; need_d <= 1'b0; end
            AC_TBL: begin
              dreg <= merged;
              cnt  <= cnt - CW'(1);
              if (dnib == 2'd3 || cnt == CW'(1)) begin
                pend_wr <= 1'b1; wr_addr <= daddr;
              end
              dnib <= dnib + 2'd1;
              snib <= snib + 2'd1;
              if (dnib == 2'd3) begin daddr <= daddr + AW'(1); need_d <= 1'b1; end
              if (snib == 2'd3) begin saddr <= saddr + AW'(1); need_s <= 1'b1; end
            end
            default: pend_wr <= 1'b0;
          endcase
        end
        ST_LEND: begin
          lines_left <= lines_left - CW'(1);
          if (lines_left == CW'(1)) begin
            done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
          end else if (stop_req) begin
            done <= 1'b1; busy <= 1'b0; stopped <= 1'b1; st <= ST_IDLE;
          end else begin
            st <= ST_LINE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: request held unchanged until accepted
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10: no memory traffic while idle
  a_r10_idle: assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_req);

  // R9: done is a single-cycle pulse with busy low
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  // R2: table reads stay inside the table page
  a_r2_tbl_page: assert property (@(posedge clk) disable iff (rst)
    (mem_req && acc == AC_TBL) |-> (mem_addr[AW-1:8] == tbl_q));

  // R8: a stop always leaves lines to do
  a_r8_stop_left: assert property (@(posedge clk) disable iff (rst)
    $rose(stopped) |-> (done && lines_left != '0));
endmodule

// File: tb/nib_blit_test.sv
module nib_blit_test;
  localparam int AW = 12;
  localparam int CW = 8;
  localparam int SB = 'h100;
  localparam int DB = 'h200;
  localparam int PITCH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-9:0] tbl_page = '0;
  logic [CW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0;
  logic [CW-1:0] width = '0, height = '0, resume_left = '0;
  logic stop_req = 1'b0;
  logic busy, done, stopped, mem_req, mem_we;
  logic [CW-1:0] lines_left;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic mrdy = 1'b0;
  logic [15:0] mrd = '0;

  logic [15:0] mem [0:4095];
  logic [15:0] pre [0:4095];
  logic [15:0] expm [0:4095];
  logic [AW-1:0] wlog [0:4095];
  int nwr = 0;
  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  nib_blit #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .tbl_page(tbl_page),
    .src_base(AW'(SB)), .src_pitch(AW'(PITCH)), .src_x(src_x), .src_y(src_y),
    .dst_base(AW'(DB)), .dst_pitch(AW'(PITCH)), .dst_x(dst_x), .dst_y(dst_y),
    .width(width), .height(height), .resume_left(resume_left), .stop_req(stop_req),
    .busy(busy), .done(done), .stopped(stopped), .lines_left(lines_left),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mrdy), .mem_rdata(mrd));

  // memory model: answers one cycle after it sees a request
  always @(posedge clk) begin
    if (rst) mrdy <= 1'b0;
    else begin
      mrdy <= mem_req && !mrdy;
      if (mem_req && !mrdy) begin
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          wlog[nwr % 4096] <= mem_addr;
          nwr <= nwr + 1;
        end else mrd <= mem[mem_addr];
      end
    end
  end

  function automatic logic [3:0] gn(input logic [15:0] w, input int k);
    return w[(3 - k) * 4 +: 4];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int tp);
    for (int i = 0; i < 4096; i++) mem[i] = 16'($urandom);
    for (int i = 0; i < 4096; i++) begin pre[i] = mem[i]; expm[i] = mem[i]; end
    tbl_page = 4'(tp);
  endtask

  // reference: processes lines l = h-1 downto stop point
  task automatic model(input int sx, sy, dx, dy, w, h, res, bit stp,
                       output int first_wa, output int nwords);
    int lo;
    nwords = 0; first_wa = -1;
    lo = stp ? h - 1 : 0;
    for (int l = h - 1; l >= lo && l >= 0; l--) begin
      int xs;
      xs = (l == h - 1 && res != 0) ? w - res : 0;
      if (first_wa < 0) first_wa = DB + (dy + l) * PITCH + (dx + xs) / 4;
      nwords += ((dx + w - 1) / 4) - ((dx + xs) / 4) + 1;
      for (int x = xs; x < w; x++) begin
        int sa, da, s, d, t;
        sa = SB + (sy + l) * PITCH + (sx + x) / 4;
        da = DB + (dy + l) * PITCH + (dx + x) / 4;
        s = gn(pre[sa], (sx + x) % 4);
        d = gn(expm[da], (dx + x) % 4);
        t = gn(pre[int'(tbl_page) * 256 + s * 16 + d], 2 * ((dy + l) % 2) + (dx + x) % 2);
        expm[da][(3 - (dx + x) % 4) * 4 +: 4] = 4'(t);
      end
    end
  endtask

  task automatic run(input int sx, sy, dx, dy, w, h, res, bit stp, bit poke, input string tag);
    int fwa, nw, w0, cyc, bad;
    bit ok;
    model(sx, sy, dx, dy, w, h, res, stp, fwa, nw);
    @(negedge clk);
    src_x = CW'(sx); src_y = CW'(sy); dst_x = CW'(dx); dst_y = CW'(dy);
    width = CW'(w); height = CW'(h); resume_left = CW'(res); stop_req = stp;
    w0 = nwr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke && busy) begin
      // R11: a second start with other parameters while busy
      repeat (4) @(negedge clk);
      dst_x = 8'd0; height = 8'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(cyc < 20000, {tag, " R9 watchdog"}, cyc, 20000);
    chk(!busy, {tag, " R9 busy low at done"}, busy, 0);
    chk(lines_left == CW'(stp ? h - 1 : 0), {tag, " R8 lines_left"}, lines_left, stp ? h - 1 : 0);
    chk(stopped == (stp && h > 1), {tag, " R8 stopped"}, stopped, stp && h > 1);
    bad = -1;
    for (int i = 0; i < 4096; i++) if (bad < 0 && mem[i] !== expm[i]) bad = i;
    ok = (bad < 0);
    if (!ok) $display("  mismatch at word %0h", bad);
    chk(ok, {tag, " R1 R2 R3 R4 R7 memory image"}, ok ? 0 : mem[bad], ok ? 0 : expm[bad]);
    chk(nwr - w0 == nw, {tag, " R5 write count"}, nwr - w0, nw);
    if (nw > 0) chk(int'(wlog[w0 % 4096]) == fwa, {tag, " R6 first write"}, wlog[w0 % 4096], fwa);
    @(negedge clk);
    chk(!mem_req && !done, {tag, " R10 R9 quiet after done"}, {mem_req, done}, 0);
  endtask

  initial begin
    int r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !stopped && !mem_req && lines_left == '0, "R9 reset state",
        {busy, done, stopped, mem_req}, 0);

    fill(4); run(1, 0, 2, 1, 7, 3, 0, 0, 0, "offsets");
    fill(5); run(3, 2, 0, 4, 9, 4, 3, 0, 0, "resume");
    fill(6); run(0, 5, 3, 3, 1, 2, 0, 0, 0, "single");
    fill(7); run(2, 1, 1, 2, 12, 5, 0, 1, 0, "stop");
    // restart of the remaining lines continues on the same memory
    for (int i = 0; i < 4096; i++) pre[i] = mem[i];
    run(2, 1, 1, 2, 12, 4, 0, 0, 0, "restart");
    fill(4); run(5, 1, 6, 0, 10, 6, 0, 0, 1, "R11 poke");
    fill(5); run(0, 0, 0, 0, 8, 0, 0, 0, 0, "R9 zero height");
    for (int k = 0; k < 8; k++) begin
      int w, h, sx, dx, sy, dy, res;
      w = 1 + $urandom % 16; h = 1 + $urandom % 8;
      sx = $urandom % (33 - w); dx = $urandom % (33 - w);
      sy = $urandom % (17 - h); dy = $urandom % (17 - h);
      res = ($urandom % 3 == 0) ? 1 + $urandom % w : 0;
      fill(4 + $urandom % 4);
      run(sx, sy, dx, dy, w, h, res, 0, 0, "random");
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule